// File: doc/BRIEF.md
# Circular Stage Window Sequencer

This block keeps the bookkeeping for a ring of identical execution stages, each able to hold one window of work. A fetch side asks for new windows. Each accepted request is placed in the stage at the tail of the ring, and the block returns that stage's index. Stages announce when their window has finished. The block retires windows strictly from the head, one per cycle, and pulses a one-hot commit strobe for each window it retires.

When a stage reports that its branch was mispredicted, the block discards every window younger than that stage. It pulses a kill mask for those stages and moves the tail so that the next allocation goes to the stage just after the offending one. The offending window and all older windows stay in flight. The per-stage valid and busy vectors show the state of the ring at every cycle.

Top module: `stage_ring_seq`

## Requirements
- R1: An accepted request (`alloc_req` and `alloc_rdy` both high at a clock edge) makes stage `alloc_idx` valid after that edge. Successive allocations take stage indices that increase by one modulo NSTG.
- R2: `alloc_rdy` is low whenever all NSTG stages are valid. Otherwise it is high, except in the case given in R9.
- R3: `stage_busy[i]` is high for a valid stage whose completion has not yet been recorded. A `stage_done[i]` pulse is recorded at the clock edge where it is sampled. A pulse on a stage that is not valid is ignored.
- R4: Windows retire in allocation order. The head window retires at the first edge at which its completion is already recorded, which is one edge after its done pulse at the earliest. Retirement clears its valid bit and raises `commit_strb` bit `i` for exactly one cycle. A younger window that finishes first waits until every older window has retired.
- R5: A misprediction (`mp_valid` high, `mp_stage` = index of a valid stage) clears the valid bit of every window younger than that stage at the next edge. `kill_mask` shows those stages for exactly one cycle. Older windows are untouched.
- R6: After a misprediction is accepted, `alloc_idx` (the tail) equals `mp_stage` + 1 modulo NSTG. `alloc_idx` always shows the stage that the next allocation will take.
- R7: A misprediction reported for a stage that is not valid has no effect: no stage is killed and the tail does not move.
- R8: If a retirement and an accepted misprediction fall in the same cycle, the retirement is applied first. This still holds when the retiring window is the mispredicting one, which leaves the ring empty.
- R9: While a misprediction is being accepted, `alloc_rdy` is low, so no window is allocated in that cycle.
- R10: Reset empties the ring: no stage is valid or busy, no strobe or kill bit is high, and the first allocation goes to stage 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Fetch side asks for a new window |
| alloc_rdy | output | 1 | A request made this cycle is accepted |
| alloc_idx | output | $clog2(NSTG) | Stage that the next accepted request takes (tail) |
| stage_done | input | NSTG | Per-stage completion pulse |
| mp_valid | input | 1 | A stage reports a mispredicted branch |
| mp_stage | input | $clog2(NSTG) | Index of the stage reporting the misprediction |
| stage_valid | output | NSTG | Stage holds a window |
| stage_busy | output | NSTG | Stage holds a window that is still executing |
| commit_strb | output | NSTG | One-cycle one-hot retirement strobe |
| kill_mask | output | NSTG | One-cycle mask of stages squashed by a misprediction |

## Verification
`alloc_rdy` and `alloc_idx` depend combinationally on the current state and on the misprediction inputs. The bench checks them one time step after it drives the inputs, before the edge. The valid, busy, commit and kill outputs change at the edge that samples a stimulus. A done pulse shows as a falling busy bit after one edge and as a commit strobe after two. The bench compares these outputs at the next falling edge against a cycle model that applies retirement, completion, squash and allocation in the required order. Directed sweeps over every head position, fill level and misprediction position are followed by a long pseudo-random run.

// File: rtl/srs_pkg.sv
package srs_pkg;

   typedef enum logic [1:0] {
      SLOT_FREE = 2'd0,
      SLOT_RUN  = 2'd1,
      SLOT_FIN  = 2'd2
   } slot_state_e;

endpackage

// File: rtl/srs_slot.sv
module srs_slot
   import srs_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic take_i,
   input  logic retire_i,
   input  logic squash_i,
   input  logic finish_i,
   output logic valid_o,
   output logic busy_o,
   output logic fin_o
);

   slot_state_e st_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q <= SLOT_FREE;
      end else if (take_i) begin
         st_q <= SLOT_RUN;
      end else if (retire_i || squash_i) begin
         st_q <= SLOT_FREE;
      end else if (finish_i && st_q == SLOT_RUN) begin
         st_q <= SLOT_FIN;
      end
   end

   assign valid_o = (st_q != SLOT_FREE);
   assign busy_o  = (st_q == SLOT_RUN);
   assign fin_o   = (st_q == SLOT_FIN);

endmodule

// File: rtl/srs_squash_mask.sv
module srs_squash_mask #(
   parameter int NSTG = 4,
   localparam int IDXW = $clog2(NSTG)
) (
   input  logic [IDXW-1:0] head_i,
   input  logic [IDXW-1:0] mark_i,
   input  logic            enable_i,
   input  logic [NSTG-1:0] valid_i,
   output logic [NSTG-1:0] kill_o
);

   logic [IDXW-1:0] limit;
   assign limit = mark_i - head_i;

   for (genvar i = 0; i < NSTG; i++) begin : g_slot
      localparam logic [IDXW-1:0] SLOT = IDXW'(i);
      logic [IDXW-1:0] age;
      assign age       = SLOT - head_i;
      assign kill_o[i] = enable_i && valid_i[i] && (age > limit);
   end

endmodule

// File: rtl/stage_ring_seq.sv
module stage_ring_seq #(
   parameter int NSTG = 4,
   localparam int IDXW = $clog2(NSTG)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            alloc_req,
   output logic            alloc_rdy,
   output logic [IDXW-1:0] alloc_idx,
   input  logic [NSTG-1:0] stage_done,
   input  logic            mp_valid,
   input  logic [IDXW-1:0] mp_stage,
   output logic [NSTG-1:0] stage_valid,
   output logic [NSTG-1:0] stage_busy,
   output logic [NSTG-1:0] commit_strb,
   output logic [NSTG-1:0] kill_mask
);

   localparam int CW = IDXW + 1;
   localparam logic [CW-1:0] FULL_CNT = CW'(NSTG);

   if (NSTG < 2 || (NSTG & (NSTG - 1)) != 0) begin : g_bad_cfg
      $error("stage_ring_seq: NSTG must be a power of two of at least 2");
   end

   logic [IDXW-1:0] head_q, tail_q;
   logic [CW-1:0]   cnt_q;
   logic [NSTG-1:0] fin;
   logic [NSTG-1:0] kill;
   logic            retire_go, squash_go, take_go;
   logic [IDXW-1:0] span;

   assign retire_go = fin[head_q];
   assign squash_go = mp_valid && stage_valid[mp_stage];
   assign alloc_rdy = (cnt_q != FULL_CNT) && !squash_go;
   assign take_go   = alloc_req && alloc_rdy;
   assign alloc_idx = tail_q;
   assign span      = mp_stage - head_q;

   srs_squash_mask #(.NSTG(NSTG)) u_squash (
      .head_i   (head_q),
      .mark_i   (mp_stage),
      .enable_i (squash_go),
      .valid_i  (stage_valid),
      .kill_o   (kill)
   );

   for (genvar i = 0; i < NSTG; i++) begin : g_stage
      localparam logic [IDXW-1:0] SLOT = IDXW'(i);
      srs_slot u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .take_i   (take_go && tail_q == SLOT),
         .retire_i (retire_go && head_q == SLOT),
         .squash_i (kill[i]),
         .finish_i (stage_done[i]),
         .valid_o  (stage_valid[i]),
         .busy_o   (stage_busy[i]),
         .fin_o    (fin[i])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q      <= '0;
         tail_q      <= '0;
         cnt_q       <= '0;
         commit_strb <= '0;
         kill_mask   <= '0;
      end else begin
         head_q      <= head_q + IDXW'(retire_go);
         commit_strb <= retire_go ? (NSTG'(1) << head_q) : '0;
         kill_mask   <= kill;
         if (squash_go) begin
            tail_q <= mp_stage + 1'b1;
            cnt_q  <= {1'b0, span} + CW'(1) - CW'(retire_go);
         end else begin
            tail_q <= tail_q + IDXW'(take_go);
            cnt_q  <= cnt_q + CW'(take_go) - CW'(retire_go);
         end
      end
   end

endmodule

// File: rtl/srs_checker.sv
module srs_checker #(
   parameter int NSTG = 4,
   localparam int IDXW = $clog2(NSTG)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            alloc_req,
   input logic            alloc_rdy,
   input logic [IDXW-1:0] alloc_idx,
   input logic            mp_valid,
   input logic [IDXW-1:0] mp_stage,
   input logic [NSTG-1:0] stage_valid,
   input logic [NSTG-1:0] stage_busy,
   input logic [NSTG-1:0] commit_strb,
   input logic [NSTG-1:0] kill_mask
);

   logic [IDXW-1:0] mark_next;
   assign mark_next = mp_stage + 1'b1;

   p_take_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_req && alloc_rdy) |=> stage_valid[$past(alloc_idx)]);

   p_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (&stage_valid) |-> !alloc_rdy);

   p_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (stage_busy & ~stage_valid) == '0);

   p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(commit_strb));

   p_retired_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_strb & stage_valid) == '0);

   p_killed_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (kill_mask & stage_valid) == '0);

   p_tail_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mp_valid && stage_valid[mp_stage]) |=> alloc_idx == $past(mark_next));

   p_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mp_valid && !stage_valid[mp_stage]) |=> kill_mask == '0);

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mp_valid && stage_valid[mp_stage]) |-> !alloc_rdy);

   p_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (stage_valid == '0 && commit_strb == '0 && alloc_idx == '0));

endmodule

bind stage_ring_seq srs_checker #(.NSTG(NSTG)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .alloc_req   (alloc_req),
   .alloc_rdy   (alloc_rdy),
   .alloc_idx   (alloc_idx),
   .mp_valid    (mp_valid),
   .mp_stage    (mp_stage),
   .stage_valid (stage_valid),
   .stage_busy  (stage_busy),
   .commit_strb (commit_strb),
   .kill_mask   (kill_mask)
);

// File: tb/stage_ring_seq_test.sv
`timescale 1ns/1ps
module stage_ring_seq_test;

   localparam int N  = 4;
   localparam int IW = $clog2(N);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          alloc_req = 1'b0;
   logic          alloc_rdy;
   logic [IW-1:0] alloc_idx;
   logic [N-1:0]  stage_done = '0;
   logic          mp_valid = 1'b0;
   logic [IW-1:0] mp_stage = '0;
   logic [N-1:0]  stage_valid, stage_busy, commit_strb, kill_mask;

   int errs = 0;
   int checks = 0;

   // reference state built from the requirements
   bit [N-1:0] m_val, m_fin, e_commit, e_kill;
   int         m_head, m_tail, m_cnt;
   bit         t_kill_r7, t_commit_r8;

   always #4 clk = ~clk;

   stage_ring_seq #(.NSTG(N)) uut (
      .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_rdy(alloc_rdy),
      .alloc_idx(alloc_idx), .stage_done(stage_done), .mp_valid(mp_valid),
      .mp_stage(mp_stage), .stage_valid(stage_valid), .stage_busy(stage_busy),
      .commit_strb(commit_strb), .kill_mask(kill_mask)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errs++;
         $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
      end
   endtask

   task automatic cmp_regs();
      chk("R1 stage_valid", 32'(stage_valid), 32'(m_val));
      chk("R3 stage_busy", 32'(stage_busy), 32'(m_val & ~m_fin));
      chk(t_commit_r8 ? "R8 commit_strb" : "R4 commit_strb", 32'(commit_strb), 32'(e_commit));
      chk(t_kill_r7 ? "R7 kill_mask" : "R5 kill_mask", 32'(kill_mask), 32'(e_kill));
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; alloc_req = 1'b0; stage_done = '0; mp_valid = 1'b0; mp_stage = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      m_val = '0; m_fin = '0; e_commit = '0; e_kill = '0;
      m_head = 0; m_tail = 0; m_cnt = 0; t_kill_r7 = 0; t_commit_r8 = 0;
      #1;
      chk("R10 valid after reset", 32'(stage_valid), 0);
      chk("R10 busy after reset", 32'(stage_busy), 0);
      chk("R10 strobes after reset", 32'(commit_strb | kill_mask), 0);
      chk("R10 tail after reset", 32'(alloc_idx), 0);
      chk("R10 ready after reset", 32'(alloc_rdy), 1);
   endtask

   // one cycle: compare registered outputs, drive, check ready/index, advance model
   task automatic step(input bit req, input bit [N-1:0] dn, input bit mv, input int ms);
      bit ok_mp, com, rdy;
      int h0, c0, keep;
      @(negedge clk);
      cmp_regs();
      alloc_req = req; stage_done = dn; mp_valid = mv; mp_stage = IW'(ms);
      #1;
      ok_mp = mv && m_val[ms];
      com   = (m_cnt > 0) && m_fin[m_head];
      rdy   = (m_cnt < N) && !ok_mp;
      chk(ok_mp ? "R9 alloc_rdy" : "R2 alloc_rdy", 32'(alloc_rdy), 32'(rdy));
      chk("R6 alloc_idx", 32'(alloc_idx), 32'(m_tail));
      t_kill_r7   = mv && !ok_mp;
      t_commit_r8 = com && ok_mp;
      e_commit = '0; e_kill = '0;
      h0 = m_head; c0 = m_cnt;
      if (com) begin
         m_val[m_head] = 0; m_fin[m_head] = 0; e_commit[m_head] = 1;
         m_head = (m_head + 1) % N; m_cnt--;
      end
      for (int i = 0; i < N; i++) if (m_val[i] && dn[i]) m_fin[i] = 1;
      if (ok_mp) begin
         keep = ((ms - h0 + N) % N) + 1;
         for (int k = keep; k < c0; k++) begin
            m_val[(h0 + k) % N] = 0; m_fin[(h0 + k) % N] = 0; e_kill[(h0 + k) % N] = 1;
         end
         m_tail = (ms + 1) % N;
         m_cnt  = keep - (com ? 1 : 0);
      end
      if (req && rdy) begin
         m_val[m_tail] = 1; m_fin[m_tail] = 0;
         m_tail = (m_tail + 1) % N; m_cnt++;
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      errs++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      bit [15:0] lfsr;
      // sweep head offset, fill level, misprediction position, same-cycle retirement
      for (int h = 0; h < N; h++)
         for (int fill = 1; fill <= N; fill++)
            for (int m = 0; m < N; m++)
               for (int flav = 0; flav < 2; flav++) begin
                  do_reset();
                  for (int r = 0; r < h; r++) begin
                     step(1, '0, 0, 0);
                     step(0, N'(1) << r, 0, 0);
                     step(0, '0, 0, 0);
                  end
                  step(0, '0, 0, 0);
                  for (int f = 0; f < fill; f++) step(1, '0, 0, 0);
                  // R4: younger finish first, must wait for head
                  step(0, N'(1) << ((h + fill - 1) % N), 0, 0);
                  if (flav == 1) step(0, N'(1) << h, 0, 0);
                  step(1, '0, 1, (h + m) % N);
                  step(1, '0, 0, 0);
                  step(0, '1, 0, 0);
                  for (int z = 0; z < N + 2; z++) step(0, '0, 0, 0);
               end
      // pseudo-random run
      do_reset();
      lfsr = 16'hACE1;
      for (int c = 0; c < 4000; c++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         step(lfsr[0] | lfsr[1], N'(lfsr[7:4] & {N{lfsr[2]}}), lfsr[8] & lfsr[9] & lfsr[3],
              int'(lfsr[12:11]) % N);
      end
      step(0, '0, 0, 0);
      @(negedge clk);
      cmp_regs();
      finish_run();
   end

endmodule